// File: doc/BRIEF.md
# Projective Point Doubling Sequencer for Binary Elliptic Curves

This block doubles one point of the binary curve y² + xy = x³ + ax² + b. The point is given in projective coordinates (X, Y, Z), where x = X/Z and y = Y/Z². Every coordinate and curve constant is an element of GF(2^M) in Montgomery form. A pulse on `start` samples the three coordinates, the constants `a` and `b` and the low part of the field polynomial. A fixed eleven-step microprogram then runs over three scratch registers. Each step may issue one field multiplication and one field addition together. The addition reads register values from before the step's multiplication result is written back.

Multiplication is done by an internal bit-serial Montgomery multiplier. One multiplication step takes M+2 cycles: one issue cycle, M iterations, and one write-back cycle. Ten steps contain a multiplication. The eleventh step is a single-cycle XOR. `done` pulses when the doubled point is ready, and the result stays on the outputs until the next accepted start. The block is meant to sit under a scalar-multiplication controller that calls it once per key bit.

Top module: `ld_point_doubler`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done_o` is 0 and `x3_o`, `y3_o` and `z3_o` are all zero.
- R2: Let mont(u,v) = u·v·x^(-M) mod P, where P = x^M + `p_i` and bit 0 of `p_i` is 1. The result is z3 = mont(mont(Z1,Z1), mont(X1,X1)).
- R3: With s = mont(b, mont(t,t)) where t = mont(Z1,Z1), and q = mont(g,g) where g = mont(X1,X1), the result is x3 = s XOR q.
- R4: The result is y3 = mont(x3, mont(a,z3) XOR mont(Y1,Y1) XOR s) XOR mont(s, z3), using s, x3 and z3 as defined in R2 and R3.
- R5: `done_o` rises exactly 10·(M+2)+1 clock edges after the edge that accepts `start`. That is 101 edges for M = 8.
- R6: `done_o` is high for exactly one cycle. After it, `x3_o`, `y3_o` and `z3_o` hold their values until a new start is accepted.
- R7: A `start` pulse that arrives while a doubling is in progress is ignored. It changes neither the latency nor the result of the running doubling.
- R8: The data inputs are sampled only on the accepting edge. Changing them during a run has no effect on that run's result.
- R9: An input with Z1 = 0 (the point at infinity) gives z3 = 0, and also gives x3 and y3 as defined in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a doubling; accepted only when idle |
| x1_i | input | M | Input X coordinate (Montgomery form) |
| y1_i | input | M | Input Y coordinate (Montgomery form) |
| z1_i | input | M | Input Z coordinate (Montgomery form) |
| a_i | input | M | Curve constant a (Montgomery form) |
| b_i | input | M | Curve constant b (Montgomery form) |
| p_i | input | M | Field polynomial without its x^M term; bit 0 must be 1 |
| x3_o | output | M | Doubled X coordinate |
| y3_o | output | M | Doubled Y coordinate |
| z3_o | output | M | Doubled Z coordinate |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
The hardest case to reach from the ports is a start pulse that arrives in the middle of a run, at the same time as the data inputs change. The bench raises `start` with new operands about thirty cycles into a doubling. It then checks that `done_o` still arrives on the original schedule and that the outputs carry the first point's double. The register hazards inside the schedule are covered by value checks. These are the additions in steps 7 to 9 that read a register while a multiplication result is written back. Each vector is compared against an independent software model that multiplies first and reduces afterwards.

// File: rtl/ld_dbl_pkg.sv
package ld_dbl_pkg;

    // Register-file slots addressed by the microprogram
    typedef enum logic [3:0] {
        SEL_NONE = 4'd0,
        SEL_X1   = 4'd1,
        SEL_Y1   = 4'd2,
        SEL_Z1   = 4'd3,
        SEL_A    = 4'd4,
        SEL_B    = 4'd5,
        SEL_T1   = 4'd6,
        SEL_T2   = 4'd7,
        SEL_T3   = 4'd8,
        SEL_X3   = 4'd9,
        SEL_Y3   = 4'd10,
        SEL_Z3   = 4'd11
    } sel_e;

    // One microprogram step: optional multiply, optional parallel add
    typedef struct packed {
        logic mul_en;
        sel_e mul_l;
        sel_e mul_r;
        sel_e mul_dst;
        logic add_en;
        sel_e add_l;
        sel_e add_r;
        sel_e add_dst;
    } step_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2,
        PH_ADD   = 2'd3
    } phase_e;

    localparam int NUM_STEPS     = 11;
    localparam int LAST_MUL_STEP = 9;
    localparam int STEP_W        = 4;
    localparam int NUM_SLOTS     = 16;

    function automatic int dbl_latency(input int m);
        return 10 * (m + 2) + 1;
    endfunction

    function automatic step_t mk_step(input logic me, input sel_e ml, input sel_e mr,
                                      input sel_e md, input logic ae, input sel_e al,
                                      input sel_e ar, input sel_e ad);
        step_t s;
        s.mul_en  = me;
        s.mul_l   = ml;
        s.mul_r   = mr;
        s.mul_dst = md;
        s.add_en  = ae;
        s.add_l   = al;
        s.add_r   = ar;
        s.add_dst = ad;
        return s;
    endfunction

    // Doubling microprogram (index 0 .. NUM_STEPS-1)
    function automatic step_t step_of(input logic [STEP_W-1:0] idx);
        step_t s;
        case (idx)
            4'd0:    s = mk_step(1'b1, SEL_Z1, SEL_Z1, SEL_T1, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd1:    s = mk_step(1'b1, SEL_X1, SEL_X1, SEL_T2, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd2:    s = mk_step(1'b1, SEL_T1, SEL_T2, SEL_Z3, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd3:    s = mk_step(1'b1, SEL_T1, SEL_T1, SEL_T1, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd4:    s = mk_step(1'b1, SEL_T2, SEL_T2, SEL_T2, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd5:    s = mk_step(1'b1, SEL_B,  SEL_T1, SEL_T1, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd6:    s = mk_step(1'b1, SEL_Y1, SEL_Y1, SEL_T2, 1'b1, SEL_T1, SEL_T2, SEL_X3);
            4'd7:    s = mk_step(1'b1, SEL_A,  SEL_Z3, SEL_T3, 1'b1, SEL_T2, SEL_T1, SEL_T2);
            4'd8:    s = mk_step(1'b1, SEL_T1, SEL_Z3, SEL_T1, 1'b1, SEL_T3, SEL_T2, SEL_T3);
            4'd9:    s = mk_step(1'b1, SEL_X3, SEL_T3, SEL_T3, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
            4'd10:   s = mk_step(1'b0, SEL_NONE, SEL_NONE, SEL_NONE, 1'b1, SEL_T3, SEL_T1, SEL_Y3);
            default: s = mk_step(1'b0, SEL_NONE, SEL_NONE, SEL_NONE, 1'b0, SEL_NONE, SEL_NONE, SEL_NONE);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gf2m_mont_mul.sv
module gf2m_mont_mul #(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [M-1:0] op_l,
    input  logic [M-1:0] op_r,
    input  logic [M-1:0] poly,
    output logic [M-1:0] result,
    output logic         done,
    output logic         busy
);
    localparam int CW = (M > 1) ? $clog2(M) : 1;
    localparam logic [CW-1:0] LAST = CW'(M - 1);

    logic [M-1:0]  acc_q, l_sh_q, r_q, p_q;
    logic [CW-1:0] cnt_q;
    logic [M-1:0]  sum, red, acc_nxt;

    // One bit-serial iteration: add l_i*r, make divisible by x, divide by x
    always_comb begin
        sum     = acc_q ^ (l_sh_q[0] ? r_q : '0);
        red     = sum ^ (sum[0] ? p_q : '0);
        acc_nxt = {sum[0], red[M-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            l_sh_q <= '0;
            r_q    <= '0;
            p_q    <= '0;
            cnt_q  <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                acc_q  <= '0;
                l_sh_q <= op_l;
                r_q    <= op_r;
                p_q    <= poly;
                cnt_q  <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                acc_q  <= acc_nxt;
                l_sh_q <= l_sh_q >> 1;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign result = acc_q;
endmodule

// File: rtl/ld_dbl_ctrl.sv
module ld_dbl_ctrl
    import ld_dbl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  mul_done,
    output logic  capture,
    output logic  mul_go,
    output logic  commit,
    output logic  busy,
    output logic  done,
    output step_t cur
);
    phase_e             ph_q;
    logic [STEP_W-1:0]  step_q;

    assign cur     = step_of(step_q);
    assign busy    = (ph_q != PH_IDLE);
    assign capture = (ph_q == PH_IDLE) && start;
    assign mul_go  = (ph_q == PH_ISSUE);
    assign commit  = ((ph_q == PH_WAIT) && mul_done) || (ph_q == PH_ADD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            step_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph_q)
                PH_IDLE: if (start) begin
                    step_q <= '0;
                    ph_q   <= PH_ISSUE;
                end
                PH_ISSUE: ph_q <= PH_WAIT;
                PH_WAIT: if (mul_done) begin
                    step_q <= step_q + 1'b1;
                    ph_q   <= (step_q == STEP_W'(LAST_MUL_STEP)) ? PH_ADD : PH_ISSUE;
                end
                PH_ADD: begin
                    done <= 1'b1;
                    ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ld_dbl_regs.sv
module ld_dbl_regs
    import ld_dbl_pkg::*;
#(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [M-1:0] x1_i,
    input  logic [M-1:0] y1_i,
    input  logic [M-1:0] z1_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic [M-1:0] p_i,
    input  logic         commit,
    input  step_t        cur,
    input  logic [M-1:0] mul_res,
    output logic [M-1:0] mul_l_v,
    output logic [M-1:0] mul_r_v,
    output logic [M-1:0] p_v,
    output logic [M-1:0] x3_v,
    output logic [M-1:0] y3_v,
    output logic [M-1:0] z3_v
);
    logic [M-1:0] rf [NUM_SLOTS];
    logic [M-1:0] p_q;
    logic [M-1:0] add_sum;

    assign mul_l_v = rf[cur.mul_l];
    assign mul_r_v = rf[cur.mul_r];
    assign add_sum = rf[cur.add_l] ^ rf[cur.add_r];
    assign p_v     = p_q;
    assign x3_v    = rf[SEL_X3];
    assign y3_v    = rf[SEL_Y3];
    assign z3_v    = rf[SEL_Z3];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) rf[i] <= '0;
            p_q <= '0;
        end else if (capture) begin
            for (int i = 0; i < NUM_SLOTS; i++) rf[i] <= '0;
            rf[SEL_X1] <= x1_i;
            rf[SEL_Y1] <= y1_i;
            rf[SEL_Z1] <= z1_i;
            rf[SEL_A]  <= a_i;
            rf[SEL_B]  <= b_i;
            p_q        <= p_i;
        end else if (commit) begin
            if (cur.mul_en) rf[cur.mul_dst] <= mul_res;
            if (cur.add_en) rf[cur.add_dst] <= add_sum;
        end
    end
endmodule

// File: rtl/ld_point_doubler.sv
module ld_point_doubler
    import ld_dbl_pkg::*;
#(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] x1_i,
    input  logic [M-1:0] y1_i,
    input  logic [M-1:0] z1_i,
    input  logic [M-1:0] a_i,
    input  logic [M-1:0] b_i,
    input  logic [M-1:0] p_i,
    output logic [M-1:0] x3_o,
    output logic [M-1:0] y3_o,
    output logic [M-1:0] z3_o,
    output logic         done_o
);
    logic         capture, mul_go, commit, busy, mul_done, mul_busy;
    step_t        cur;
    logic [M-1:0] mul_l_v, mul_r_v, p_v, mul_res;

    ld_dbl_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mul_done (mul_done),
        .capture  (capture),
        .mul_go   (mul_go),
        .commit   (commit),
        .busy     (busy),
        .done     (done_o),
        .cur      (cur)
    );

    ld_dbl_regs #(.M(M)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .x1_i    (x1_i),
        .y1_i    (y1_i),
        .z1_i    (z1_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .p_i     (p_i),
        .commit  (commit),
        .cur     (cur),
        .mul_res (mul_res),
        .mul_l_v (mul_l_v),
        .mul_r_v (mul_r_v),
        .p_v     (p_v),
        .x3_v    (x3_o),
        .y3_v    (y3_o),
        .z3_v    (z3_o)
    );

    gf2m_mont_mul #(.M(M)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .go     (mul_go),
        .op_l   (mul_l_v),
        .op_r   (mul_r_v),
        .poly   (p_v),
        .result (mul_res),
        .done   (mul_done),
        .busy   (mul_busy)
    );
endmodule

// File: rtl/ld_dbl_checker.sv
module ld_dbl_checker #(
    parameter int M = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         mul_go,
    input logic         mul_busy,
    input logic         done_o,
    input logic [M-1:0] x3_o,
    input logic [M-1:0] y3_o,
    input logic [M-1:0] z3_o
);
    localparam int LAT = ld_dbl_pkg::dbl_latency(M);

    logic [15:0] run_cnt;
    logic        run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            run_q   <= 1'b0;
        end else if (start && !busy) begin
            run_cnt <= '0;
            run_q   <= 1'b1;
        end else begin
            if (run_q) run_cnt <= run_cnt + 1'b1;
            if (done_o) run_q <= 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !done_o && x3_o == '0 && y3_o == '0 && z3_o == '0) // R1
        else $error("reset state");
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst) done_o |-> run_q && run_cnt == 16'(LAT)) // R5
        else $error("latency");
    AST_ONE_MUL_INFLIGHT: assert property (@(posedge clk) disable iff (rst) mul_go |-> !mul_busy) // R5
        else $error("multiplier overlap");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o) // R6
        else $error("done width");
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(x3_o) && $stable(y3_o) && $stable(z3_o)) // R6
        else $error("hold");
    AST_IDLE_NO_MUL: assert property (@(posedge clk) disable iff (rst) !busy |-> !mul_busy && !mul_go) // R7
        else $error("idle multiplier");
endmodule

bind ld_point_doubler ld_dbl_checker #(.M(M)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .mul_go   (mul_go),
    .mul_busy (mul_busy),
    .done_o   (done_o),
    .x3_o     (x3_o),
    .y3_o     (y3_o),
    .z3_o     (z3_o)
);

// File: tb/ld_point_doubler_tb.sv
module ld_point_doubler_tb;
    localparam int M   = 8;
    localparam int LAT = 10 * (M + 2) + 1;
    localparam logic [M-1:0] POLY = 8'h1B;
    localparam int NV  = 6;
    // {x1, y1, z1, a, b}
    localparam logic [5*M-1:0] VEC [NV] = '{
        40'h01_01_01_01_01,
        40'h53_CA_07_00_5A,
        40'hFF_FF_FF_FF_FF,
        40'h80_01_3C_E1_02,
        40'h12_34_56_78_9A,
        40'hA5_5A_C3_3C_81
    };

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [M-1:0] x1, y1, z1, a, b, p;
    logic [M-1:0] x3, y3, z3;
    logic done;
    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ld_point_doubler #(.M(M)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .x1_i(x1), .y1_i(y1), .z1_i(z1), .a_i(a), .b_i(b), .p_i(p),
        .x3_o(x3), .y3_o(y3), .z3_o(z3), .done_o(done)
    );

    // Reference: full product first, then divide by x^M modulo P
    function automatic logic [M-1:0] mont(input logic [M-1:0] u, input logic [M-1:0] v);
        logic [2*M-1:0] pr = '0;
        logic [2*M-1:0] pf = (2*M)'({1'b1, POLY});
        for (int i = 0; i < M; i++) if (u[i]) pr ^= (2*M)'(v) << i;
        for (int i = 0; i < M; i++) begin
            if (pr[0]) pr ^= pf;
            pr >>= 1;
        end
        return pr[M-1:0];
    endfunction

    function automatic logic [3*M-1:0] model(input logic [M-1:0] xx, yy, zz, aa, bb);
        logic [M-1:0] zsq, xsq, zz3, s, q, xx3, inner, yy3;
        zsq   = mont(zz, zz);
        xsq   = mont(xx, xx);
        zz3   = mont(zsq, xsq);
        s     = mont(bb, mont(zsq, zsq));
        q     = mont(xsq, xsq);
        xx3   = s ^ q;
        inner = mont(aa, zz3) ^ mont(yy, yy) ^ s;
        yy3   = mont(xx3, inner) ^ mont(s, zz3);
        return {xx3, yy3, zz3};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Start a doubling and count edges until done; optional disturbance mid-run
    task automatic run(input logic [5*M-1:0] v, input bit disturb, output int lat);
        {x1, y1, z1, a, b} = v;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (disturb && lat == 30) begin
                {x1, y1, z1, a, b} = ~v;
                start = 1'b1;
            end
            if (disturb && lat == 31) start = 1'b0;
        end
        if (lat >= 400) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: done never rose");
        end
    endtask

    initial begin
        int lat;
        logic [3*M-1:0] e;
        logic [M-1:0] hx, hy, hz;
        p = POLY;
        {x1, y1, z1, a, b} = '0;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 x3 after reset", 32'(x3), 32'd0);
        chk("R1 y3 after reset", 32'(y3), 32'd0);
        chk("R1 z3 after reset", 32'(z3), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);

        for (int i = 0; i < NV; i++) begin
            e = model(VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
            run(VEC[i], 1'b0, lat);
            chk("R5 latency", 32'(lat), 32'(LAT));
            chk("R2 z3", 32'(z3), 32'(e[M-1:0]));
            chk("R3 x3", 32'(x3), 32'(e[3*M-1:2*M]));
            chk("R4 y3", 32'(y3), 32'(e[2*M-1:M]));
            @(negedge clk);
        end

        // R6: done one cycle, outputs held while idle
        e = model(8'h3D, 8'h77, 8'h19, 8'h05, 8'hC2);
        run({8'h3D, 8'h77, 8'h19, 8'h05, 8'hC2}, 1'b0, lat);
        hx = x3; hy = y3; hz = z3;
        @(negedge clk);
        chk("R6 done pulse width", 32'(done), 32'd0);
        {x1, y1, z1, a, b} = '1;
        repeat (20) @(negedge clk);
        chk("R6 x3 held", 32'(x3), 32'(hx));
        chk("R6 y3 held", 32'(y3), 32'(hy));
        chk("R6 z3 held", 32'(z3), 32'(hz));

        // R7/R8: start and new operands mid-run are ignored
        e = model(8'h6E, 8'h2B, 8'h91, 8'h44, 8'h0F);
        run({8'h6E, 8'h2B, 8'h91, 8'h44, 8'h0F}, 1'b1, lat);
        chk("R7 latency unchanged", 32'(lat), 32'(LAT));
        chk("R8 x3 uses sampled inputs", 32'(x3), 32'(e[3*M-1:2*M]));
        chk("R8 y3 uses sampled inputs", 32'(y3), 32'(e[2*M-1:M]));
        chk("R7 z3 of first run", 32'(z3), 32'(e[M-1:0]));
        @(negedge clk);

        // R9: point at infinity
        e = model(8'hB7, 8'h4C, 8'h00, 8'h9E, 8'h23);
        run({8'hB7, 8'h4C, 8'h00, 8'h9E, 8'h23}, 1'b0, lat);
        chk("R9 z3 zero", 32'(z3), 32'd0);
        chk("R9 x3", 32'(x3), 32'(e[3*M-1:2*M]));
        chk("R9 y3", 32'(y3), 32'(e[2*M-1:M]));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule